// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Read

This block is a free-running 16-bit up-counter that advances once for each clock cycle on which an external prescaler tick is high. The counter clears on reset and wraps silently at the top of its range. It has no write path, so software cannot change its value. The full count is driven out every cycle for use by compare logic.

An 8-bit processor bus reads the count as two byte registers. The upper byte sits at the lower address and is read first. A read of the upper byte also copies the lower byte into a holding register. If the very next cycle brings a lower-byte read, that read returns the held byte. The two accesses then form one consistent 16-bit sample, even when the counter has moved on, including a carry from the lower byte into the upper byte.

Top module: `tick_timer16`

## Requirements
- R1: While `rst` is high at a rising edge, the count and the read data are cleared to 0x0000 and 0x00.
- R2: The count grows by exactly one after each edge at which `tick_i` is high, and keeps its value after each edge at which `tick_i` is low.
- R3: A tick while the count is 0xFFFF takes it to 0x0000.
- R4: A read with `rd_sel_i` = 0 (upper byte) places bits 15:8 of the count, as they stood at that edge, on `rd_data_o` one cycle later.
- R5: A read with `rd_sel_i` = 1 (lower byte) in the cycle directly after an upper-byte read returns bits 7:0 of the count as they stood at the upper-byte read.
- R6: A lower-byte read that does not directly follow an upper-byte read returns bits 7:0 of the live count at its own edge.
- R7: An upper-byte read followed at once by a lower-byte read yields one 16-bit sample equal to the count at the upper-byte read, also when a carry into the upper byte happens between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Prescaled count enable |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | Byte select: 0 = upper byte, 1 = lower byte |
| rd_data_o | output | 8 | Registered read data |
| count_o | output | 16 | Live counter value |

## Verification
Pairs of reads are issued while the tick runs without a pause. This shows whether the lower byte comes from the snapshot or from the moving counter. Pairs timed so that the lower byte rolls from 0xFF to 0x00 between the two accesses would expose a torn sample. Lower-byte reads after an idle cycle show that the snapshot is used only once. Tick patterns with gaps, and a full run through 0xFFFF, separate the enable gating from the wrap.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned BUS_W_DEF = 8;

  typedef enum logic {
    SEL_UPPER = 1'b0,
    SEL_LOWER = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= count_q + ONE;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/tick_timer_rdport.sv
module tick_timer_rdport
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [BUS_W-1:0] rd_data
);
  localparam int unsigned LO_MSB = BUS_W - 1;
  localparam int unsigned HI_LSB = CNT_W - BUS_W;

  logic [BUS_W-1:0] hold_q;
  logic             hold_vld_q;
  logic [BUS_W-1:0] data_q;
  logic             upper_rd;
  logic             lower_rd;

  assign upper_rd = rd_en && (byte_sel_e'(rd_sel) == SEL_UPPER);
  assign lower_rd = rd_en && (byte_sel_e'(rd_sel) == SEL_LOWER);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      data_q     <= '0;
    end else begin
      hold_vld_q <= upper_rd;
      if (upper_rd) begin
        data_q <= count[CNT_W-1:HI_LSB];
        hold_q <= count[LO_MSB:0];
      end else if (lower_rd) begin
        data_q <= hold_vld_q ? hold_q : count[LO_MSB:0];
      end
    end
  end

  assign rd_data = data_q;
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned BUS_W = BUS_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count;

  tick_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_i),
    .count (count)
  );

  tick_timer_rdport #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_rdport (
    .clk     (clk),
    .rst     (rst),
    .count   (count),
    .rd_en   (rd_en_i),
    .rd_sel  (rd_sel_i),
    .rd_data (rd_data_o)
  );

  assign count_o = count;
endmodule

// File: rtl/tick_timer16_chk.sv
module tick_timer16_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             rd_en_i,
  input logic             rd_sel_i,
  input logic [BUS_W-1:0] rd_data_o,
  input logic [CNT_W-1:0] count_o
);
  localparam int unsigned HI_LSB = CNT_W - BUS_W;

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && rd_data_o == '0));

  // R2, R3 (the sum wraps at the counter width)
  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> count_o == CNT_W'($past(count_o) + 1'b1));

  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(count_o));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && count_o == '1) |=> count_o == '0);

  // R4
  p_upper_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !rd_sel_i) |=> rd_data_o == $past(count_o[CNT_W-1:HI_LSB]));

  // R5, R7
  p_snapshot_low_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !rd_sel_i) ##1 (rd_en_i && rd_sel_i)
      |=> rd_data_o == $past(count_o[BUS_W-1:0], 2));

  // R6
  p_live_low_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_sel_i && !$past(rd_en_i && !rd_sel_i))
      |=> rd_data_o == $past(count_o[BUS_W-1:0]));
endmodule

bind tick_timer16 tick_timer16_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_i    (tick_i),
  .rd_en_i   (rd_en_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .count_o   (count_o)
);

// File: tb/tick_timer16_tb.sv
`timescale 1ns/1ps
module tick_timer16_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        rd_sel_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic [15:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [15:0] ref_cnt = 16'h0000;
  logic [15:0] ref_prev = 16'h0000;

  always #2 clk = ~clk;

  tick_timer16 u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .rd_en_i(rd_en_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .count_o(count_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the model updated.
  task automatic step(input logic t, input logic en, input logic sel);
    tick_i = t; rd_en_i = en; rd_sel_i = sel;
    @(posedge clk);
    @(negedge clk);
    ref_prev = ref_cnt;
    if (t) ref_cnt = ref_cnt + 16'd1;
    tick_i = 1'b0; rd_en_i = 1'b0; rd_sel_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    ref_cnt = 16'h0000;
    ref_prev = 16'h0000;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count_o, 16'h0000);
    chk("R1 rd_data", {8'h00, rd_data_o}, 16'h0000);
  endtask

  task automatic t_gating();
    for (int i = 0; i < 12; i++) begin
      step(i % 3 != 0, 1'b0, 1'b0);
      chk("R2 gated count", count_o, ref_cnt);
    end
  endtask

  // Upper read then lower read on the next cycle, counter ticking throughout.
  task automatic read_pair(input string req);
    logic [15:0] sample;
    logic [15:0] got;
    step(1'b1, 1'b1, 1'b0);
    sample = ref_prev;
    got[15:8] = rd_data_o;
    chk("R4 upper byte", {8'h00, rd_data_o}, {8'h00, sample[15:8]});
    step(1'b1, 1'b1, 1'b1);
    got[7:0] = rd_data_o;
    chk("R5 held low byte", {8'h00, rd_data_o}, {8'h00, sample[7:0]});
    chk(req, got, sample);
  endtask

  task automatic t_pairs();
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 1'b0);
      read_pair("R7 coherent pair");
    end
  endtask

  task automatic t_live_low();
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R6 live low after gap", {8'h00, rd_data_o}, {8'h00, ref_prev[7:0]});
    step(1'b1, 1'b1, 1'b1);
    chk("R6 second live low", {8'h00, rd_data_o}, {8'h00, ref_prev[7:0]});
  endtask

  task automatic t_carry();
    while (ref_cnt[7:0] != 8'hFF) step(1'b1, 1'b0, 1'b0);
    read_pair("R7 pair across carry");
    chk("R7 count moved past carry", count_o[15:8], ref_cnt[15:8]);
  endtask

  task automatic t_wrap();
    while (ref_cnt != 16'hFFFE) step(1'b1, 1'b0, 1'b0);
    chk("R2 count before wrap", count_o, 16'hFFFE);
    read_pair("R7 pair at top of range");
    chk("R3 wrapped count", count_o, 16'h0000);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 counting resumes", count_o, 16'h0001);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_gating();
    t_pairs();
    t_live_low();
    t_carry();
    t_wrap();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule